// File: doc/BRIEF.md
# I2C Slave Receiver with Overrun-Gated Acknowledge

This block is a synchronous I2C slave engine. It samples the SCL and SDA lines through a synchronizer and recognises START and STOP conditions. Incoming bits are shifted into an internal register, and the first byte (or first two bytes) after START are matched against a host-programmed own address, in 7-bit or 10-bit form. On a match the block pulls SDA low on the ninth clock. Every byte it accepts goes to a receive buffer that the host reads.

The block refuses to overwrite data the host has not yet taken. While the buffer-full flag or the overflow flag is set, an addressed byte is neither acknowledged nor stored, but it still raises the interrupt flag. A byte refused while the buffer is full also sets the overflow flag. The buffer-full flag clears when the host reads the buffer. The overflow flag clears only through a dedicated host clear.

The mode code has two jobs. It picks the addressing width, and it decides whether bus START and STOP events also raise the interrupt. After a 7-bit read address the block shifts out a host-loaded byte. It never stretches SCL. Its only bus drive is an open-drain pull-down on SDA.

Top module: `i2c_slave_ovr`

## Requirements
- R1: After reset, rxData is 0x00, and bufFull, overflow, irq, startSeen, stopSeen and sdaDrvLow are all 0.
- R2: cfgWe latches cfgMode and cfgAddr. The mode codes are:
  - 4'h1: 7-bit slave.
  - 4'h2: 10-bit slave.
  - 4'h5: 7-bit slave with bus-event interrupts.
  - 4'h6: 10-bit slave with bus-event interrupts.
  - 4'h8: firmware-master, where the slave logic ignores addresses.
  - Every other code leaves the slave idle.
- R3: In 7-bit modes, the first byte after START matches when its upper seven bits equal cfgAddr[6:0] and are not all zero, so 0x00 is never recognised. A match is acknowledged with SDA low during the ninth SCL high phase. Bit 0 of that byte is R/W, with 1 meaning read.
- R4: In 10-bit modes, the first byte must equal {5'b11110, cfgAddr[9:8], 1'b0}, and the second byte must equal cfgAddr[7:0]. Both bytes are acknowledged, and so are the data bytes that follow. A mismatch is not acknowledged, and the bus is then ignored until the next START.
- R5: An accepted byte is copied into rxData and sets bufFull. This includes address bytes. A one-cycle rdStb clears bufFull.
- R6: An addressed byte that completes while bufFull or overflow is already set is refused:
  - It is not acknowledged.
  - rxData keeps its value.
  - overflow is set if bufFull was set.
  - The bus is ignored until the next START.
- R7: irq is set by the following, and cleared by irqClr:
  - every byte that completes while the block is addressed, refused bytes included;
  - the ninth clock of every transmitted byte.
  An unmatched address byte leaves irq unchanged.
- R8: Only ovClr clears overflow. rdStb does not clear it.
- R9: A START condition (SDA falling while SCL is high) sets startSeen and clears stopSeen. A STOP condition (SDA rising while SCL is high) does the reverse.
- R10: START and STOP raise irq only in modes 4'h5, 4'h6 and 4'h8.
- R11: After an accepted 7-bit read address, the block sends the byte loaded by txWe, MSB first, changing SDA only while SCL is low. It then releases SDA for the ninth clock. A master ACK makes it send the loaded byte again. A master NACK releases SDA, and the bus is ignored until the next START.
- R12: sdaDrvLow is the only bus drive (1 pulls SDA low, 0 releases it). It is 0 from the clock after enable goes low, and a disabled block acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| cfgWe | input | 1 | Write strobe for mode and own address |
| cfgMode | input | 4 | Mode code |
| cfgAddr | input | 10 | Own slave address |
| txWe | input | 1 | Write strobe for the transmit byte |
| txData | input | 8 | Byte to send on reads |
| rdStb | input | 1 | Host read of the receive buffer |
| ovClr | input | 1 | Clear the overflow flag |
| irqClr | input | 1 | Clear the interrupt flag |
| rxData | output | 8 | Receive buffer |
| bufFull | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| startSeen | output | 1 | Last bus event was START |
| stopSeen | output | 1 | Last bus event was STOP |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bound checker enforces several rules on every cycle:
- the buffer and overflow flags stay set until their own clear;
- rxData changes only in the cycle that newly sets bufFull, with no overflow pending;
- overflow rises only when the buffer was already full;
- startSeen and stopSeen are never set together;
- a disabled block never pulls SDA.

Some behaviour depends on whole bus transactions, so only the bench scenarios can show it:
- which address patterns draw an acknowledge in each mode;
- that 0x00 is never recognised;
- the refusal of a byte after an overrun, and the recovery after ovClr;
- the interrupt on START and STOP in each mode;
- the bit order of transmitted data.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int MODE_W = 4;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [MODE_W-1:0] MODE_7B      = 4'h1;
  localparam logic [MODE_W-1:0] MODE_10B     = 4'h2;
  localparam logic [MODE_W-1:0] MODE_7B_IRQ  = 4'h5;
  localparam logic [MODE_W-1:0] MODE_10B_IRQ = 4'h6;
  localparam logic [MODE_W-1:0] MODE_FWM     = 4'h8;

  // 10-bit header prefix, placed ahead of the two upper address bits
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACKWAIT, ST_ACK, ST_TX, ST_TXACK
  } ctlState_t;

  typedef enum logic [1:0] {K_ADDR1, K_ADDR2, K_DATA} byteKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadBuf;
    logic refuse;
    logic byteIrq;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  function automatic logic isSeven(input logic [MODE_W-1:0] m);
    return (m == MODE_7B) || (m == MODE_7B_IRQ);
  endfunction

  function automatic logic isTen(input logic [MODE_W-1:0] m);
    return (m == MODE_10B) || (m == MODE_10B_IRQ);
  endfunction

  function automatic logic busIrqMode(input logic [MODE_W-1:0] m);
    return (m == MODE_7B_IRQ) || (m == MODE_10B_IRQ) || (m == MODE_FWM);
  endfunction

endpackage

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              cfgWe,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              txWe,
  input  logic [BYTE_W-1:0] txData,
  input  logic              rdStb,
  input  logic              ovClr,
  input  logic              irqClr,
  input  dpStrobe_t         st,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] byteNow,
  output logic [MODE_W-1:0] modeReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic              txMsb,
  output logic [BYTE_W-1:0] rxData,
  output logic              bufFull,
  output logic              overflow,
  output logic              irq,
  output logic              startSeen,
  output logic              stopSeen
);

  logic              sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] txHold, txShift;

  // Line synchronizers; idle bus level is high
  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclS <= 1'b1;
          sdaS <= 1'b1;
        end else begin
          sclS <= sclIn;
          sdaS <= sdaIn;
        end
      end
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclPipe[SYNC_STAGES-1];
      assign sdaS = sdaPipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = enable & sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = enable & sclS & sclD & ~sdaD & sdaS;
  assign sdaBit  = sdaS;
  assign byteNow = {shiftReg, sdaS};
  assign txMsb   = txShift[BYTE_W-1];

  // Host-written configuration and transmit byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      addrReg <= '0;
      txHold  <= '0;
    end else begin
      if (cfgWe) begin
        modeReg <= cfgMode;
        addrReg <= cfgAddr;
      end
      if (txWe) txHold <= txData;
    end
  end

  // Receive path and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      bufFull   <= 1'b0;
      overflow  <= 1'b0;
      irq       <= 1'b0;
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      if (st.shiftIn) shiftReg <= byteNow[BYTE_W-2:0];
      if (st.loadBuf) rxData <= byteNow;

      if (st.loadBuf)   bufFull <= 1'b1;
      else if (rdStb)   bufFull <= 1'b0;

      if (st.refuse && bufFull) overflow <= 1'b1;
      else if (ovClr)           overflow <= 1'b0;

      if (st.byteIrq || (busIrqMode(modeReg) && (startEv || stopEv)))
        irq <= 1'b1;
      else if (irqClr)
        irq <= 1'b0;

      if (startEv) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
      end else if (stopEv) begin
        startSeen <= 1'b0;
        stopSeen  <= 1'b1;
      end
    end
  end

  // Transmit shifter; released bits shift in as ones
  always_ff @(posedge clk) begin
    if (!rstN)           txShift <= '1;
    else if (st.loadTx)  txShift <= txHold;
    else if (st.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] byteNow,
  input  logic [MODE_W-1:0] modeReg,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic              bufFull,
  input  logic              overflow,
  input  logic              txMsb,
  output dpStrobe_t         st,
  output logic              sdaDrvLow
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctlState_t        state;
  byteKind_t        kind, nextKind;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead, mAck;
  logic             want, readReq, gated, byteEnd, slaveMode;

  assign slaveMode = isSeven(modeReg) || isTen(modeReg);
  assign gated     = bufFull | overflow;
  assign byteEnd   = (state == ST_RECV) && sclRise && (bitCnt == LAST_BIT);

  // Match decision on the completed byte
  always_comb begin
    want     = 1'b0;
    readReq  = 1'b0;
    nextKind = K_DATA;
    unique case (kind)
      K_ADDR1: begin
        if (isSeven(modeReg)) begin
          want    = (byteNow[BYTE_W-1:1] == addrReg[BYTE_W-2:0]) &&
                    (byteNow[BYTE_W-1:1] != '0);
          readReq = byteNow[0];
        end else if (isTen(modeReg)) begin
          want     = (byteNow == {HDR10, addrReg[ADDR_W-1:ADDR_W-2], 1'b0});
          nextKind = K_ADDR2;
        end
      end
      K_ADDR2: want = (byteNow == addrReg[BYTE_W-1:0]);
      default: want = 1'b1;
    endcase
  end

  // Strobes toward the datapath
  always_comb begin
    st = '0;
    if (enable && !startEv && !stopEv) begin
      unique case (state)
        ST_RECV: begin
          st.shiftIn = sclRise;
          if (byteEnd && want) begin
            st.byteIrq = 1'b1;
            st.loadBuf = !gated;
            st.refuse  = gated;
          end
        end
        ST_ACK:   st.loadTx  = sclFall && isRead;
        ST_TX:    st.shiftTx = sclFall && (bitCnt != LAST_BIT);
        ST_TXACK: begin
          st.byteIrq = sclRise;
          st.loadTx  = sclFall && mAck;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR1;
      bitCnt <= '0;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else if (!enable) begin
      state <= ST_IDLE;
    end else if (startEv) begin
      state  <= slaveMode ? ST_RECV : ST_IDLE;
      kind   <= K_ADDR1;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            if (want && !gated) begin
              state  <= ST_ACKWAIT;
              isRead <= (kind == K_ADDR1) && isSeven(modeReg) && readReq;
              kind   <= nextKind;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACKWAIT: if (sclFall) state <= ST_ACK;
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= isRead ? ST_TX : ST_RECV;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) state <= ST_TXACK;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) mAck <= !sdaBit;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= mAck ? ST_TX : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Open-drain drive decoded from registered state
  assign sdaDrvLow = (state == ST_ACK) || ((state == ST_TX) && !txMsb);

endmodule

// File: rtl/i2c_slave_ovr.sv
module i2c_slave_ovr
  import i2c_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaDrvLow,
  input  logic        cfgWe,
  input  logic [3:0]  cfgMode,
  input  logic [9:0]  cfgAddr,
  input  logic        txWe,
  input  logic [7:0]  txData,
  input  logic        rdStb,
  input  logic        ovClr,
  input  logic        irqClr,
  output logic [7:0]  rxData,
  output logic        bufFull,
  output logic        overflow,
  output logic        startSeen,
  output logic        stopSeen,
  output logic        irq
);

  dpStrobe_t         strobes;
  logic              sclRise, sclFall, startEv, stopEv, sdaBit, txMsb;
  logic [BYTE_W-1:0] byteNow;
  logic [MODE_W-1:0] modeReg;
  logic [ADDR_W-1:0] addrReg;

  i2c_slave_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgAddr(cfgAddr),
    .txWe(txWe), .txData(txData),
    .rdStb(rdStb), .ovClr(ovClr), .irqClr(irqClr),
    .st(strobes),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .sdaBit(sdaBit), .byteNow(byteNow), .modeReg(modeReg), .addrReg(addrReg),
    .txMsb(txMsb), .rxData(rxData), .bufFull(bufFull), .overflow(overflow),
    .irq(irq), .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_slave_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .sdaBit(sdaBit), .byteNow(byteNow), .modeReg(modeReg), .addrReg(addrReg),
    .bufFull(bufFull), .overflow(overflow), .txMsb(txMsb),
    .st(strobes), .sdaDrvLow(sdaDrvLow)
  );

endmodule

// File: rtl/i2c_slave_chk.sv
module i2c_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       rdStb,
  input logic       ovClr,
  input logic       irqClr,
  input logic       bufFull,
  input logic       overflow,
  input logic       irq,
  input logic       startSeen,
  input logic       stopSeen,
  input logic [7:0] rxData,
  input logic       sdaDrvLow
);

  p_release_when_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sdaDrvLow);

  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && !rdStb |=> bufFull);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ovClr |=> overflow);

  p_ovf_needs_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(bufFull));

  p_no_load_when_refused_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> bufFull && !$past(bufFull) && !$past(overflow));

  p_sp_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqClr |=> irq);

endmodule

bind i2c_slave_ovr i2c_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .rdStb(rdStb), .ovClr(ovClr),
  .irqClr(irqClr), .bufFull(bufFull), .overflow(overflow), .irq(irq),
  .startSeen(startSeen), .stopSeen(stopSeen), .rxData(rxData),
  .sdaDrvLow(sdaDrvLow)
);

// File: tb/sim_i2c_slave_ovr.sv
module sim_i2c_slave_ovr;

  localparam int H = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       mScl = 1'b1, mSda = 1'b1;
  logic       sdaBus;
  logic       sdaDrvLow;
  logic       cfgWe = 1'b0, txWe = 1'b0, rdStb = 1'b0, ovClr = 1'b0, irqClr = 1'b0;
  logic [3:0] cfgMode = '0;
  logic [9:0] cfgAddr = '0;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic       bufFull, overflow, startSeen, stopSeen, irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign sdaBus = mSda & ~sdaDrvLow;

  i2c_slave_ovr u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDrvLow(sdaDrvLow), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgAddr(cfgAddr),
    .txWe(txWe), .txData(txData), .rdStb(rdStb), .ovClr(ovClr), .irqClr(irqClr),
    .rxData(rxData), .bufFull(bufFull), .overflow(overflow),
    .startSeen(startSeen), .stopSeen(stopSeen), .irq(irq)
  );

  // {mode, own address, first byte, expected acknowledge}
  localparam logic [22:0] VEC [0:8] = '{
    {4'h1, 10'h02A, 8'h54, 1'b1},
    {4'h1, 10'h02A, 8'h56, 1'b0},
    {4'h1, 10'h000, 8'h00, 1'b0},
    {4'h5, 10'h07F, 8'hFE, 1'b1},
    {4'h2, 10'h2C5, 8'hF4, 1'b1},
    {4'h2, 10'h2C5, 8'hF2, 1'b0},
    {4'h8, 10'h02A, 8'h54, 1'b0},
    {4'h3, 10'h02A, 8'h54, 1'b0},
    {4'h2, 10'h02A, 8'h54, 1'b0}
  };

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] m, input logic [9:0] a);
    cfgMode = m; cfgAddr = a; cfgWe = 1'b1; w(1); cfgWe = 1'b0;
  endtask

  task automatic pulseRd();  rdStb = 1'b1;  w(1); rdStb = 1'b0;  endtask
  task automatic pulseIrq(); irqClr = 1'b1; w(1); irqClr = 1'b0; endtask
  task automatic pulseOv();  ovClr = 1'b1;  w(1); ovClr = 1'b0;  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1; w(H);
    mSda = 1'b0; w(H);
    mScl = 1'b0; w(H);
  endtask

  task automatic busStop();
    mScl = 1'b0; mSda = 1'b0; w(H);
    mScl = 1'b1; w(H);
    mSda = 1'b1; w(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; w(H);
      mScl = 1'b1; w(H);
      mScl = 1'b0;
    end
    mSda = 1'b1; w(H);
    mScl = 1'b1; w(H/2);
    ack = !sdaBus;
    w(H/2);
    mScl = 1'b0; w(2);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; w(H);
      mScl = 1'b1; w(H/2);
      b[i] = sdaBus;
      w(H/2);
      mScl = 1'b0;
    end
    mSda = !giveAck; w(H);
    mScl = 1'b1; w(H);
    mScl = 1'b0; w(2);
    mSda = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    w(4);
    rstN = 1'b1;
    w(2);
    // R1 reset state
    chk("R1 rxData", rxData, 8'h00);
    chk("R1 bufFull", bufFull, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irq", irq, 0);
    chk("R1 startSeen", startSeen, 0);
    chk("R1 stopSeen", stopSeen, 0);
    chk("R1 sdaDrvLow", sdaDrvLow, 0);

    // Address table: R2 R3 R4 R5
    for (int k = 0; k < 9; k++) begin
      cfg(VEC[k][22:19], VEC[k][18:9]);
      busStart();
      sendByte(VEC[k][8:1], ack);
      chk("R2 R3 R4 table ack", ack, VEC[k][0]);
      chk("R5 table bufFull", bufFull, VEC[k][0]);
      busStop();
      pulseRd();
      pulseIrq();
    end

    // 7-bit write with data
    cfg(4'h1, 10'h02A);
    busStart();
    chk("R9 start sets S", startSeen, 1);
    chk("R9 start clears P", stopSeen, 0);
    chk("R10 no start irq in mode 1", irq, 0);
    sendByte(8'h54, ack);
    chk("R3 address ack", ack, 1);
    chk("R5 address loaded", rxData, 8'h54);
    chk("R7 irq on address", irq, 1);
    pulseRd();
    chk("R5 read clears full", bufFull, 0);
    pulseIrq();
    sendByte(8'hA5, ack);
    chk("R5 data ack", ack, 1);
    chk("R5 data loaded", rxData, 8'hA5);
    pulseRd();
    pulseIrq();
    busStop();
    chk("R9 stop sets P", stopSeen, 1);
    chk("R9 stop clears S", startSeen, 0);
    chk("R10 no stop irq in mode 1", irq, 0);

    // Overrun
    busStart();
    sendByte(8'h54, ack);
    chk("R6 first ack", ack, 1);
    pulseIrq();
    sendByte(8'h3C, ack);
    chk("R6 refused nack", ack, 0);
    chk("R6 buffer unchanged", rxData, 8'h54);
    chk("R6 overflow set", overflow, 1);
    chk("R7 irq on refused", irq, 1);
    sendByte(8'h11, ack);
    chk("R6 ignored after refusal", ack, 0);
    busStop();
    pulseRd();
    chk("R8 read keeps overflow", overflow, 1);
    chk("R5 read clears full", bufFull, 0);
    pulseIrq();
    busStart();
    pulseIrq();
    sendByte(8'h54, ack);
    chk("R6 overflow alone refuses", ack, 0);
    chk("R6 no load on refusal", bufFull, 0);
    chk("R7 irq on refused address", irq, 1);
    busStop();
    pulseOv();
    chk("R8 ovClr clears", overflow, 0);
    busStart();
    sendByte(8'h54, ack);
    chk("R8 accepted after clear", ack, 1);
    busStop();
    pulseRd();

    // 10-bit write
    cfg(4'h2, 10'h2C5);
    busStart();
    sendByte(8'hF4, ack);
    chk("R4 header ack", ack, 1);
    pulseRd();
    sendByte(8'hC5, ack);
    chk("R4 low byte ack", ack, 1);
    pulseRd();
    sendByte(8'h77, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 data loaded", rxData, 8'h77);
    pulseRd();
    busStop();
    busStart();
    sendByte(8'hF4, ack);
    pulseRd();
    pulseIrq();
    sendByte(8'hC4, ack);
    chk("R4 low byte mismatch", ack, 0);
    chk("R4 mismatch no load", bufFull, 0);
    chk("R7 mismatch no irq", irq, 0);
    busStop();

    // Bus-event interrupts
    cfg(4'h5, 10'h02A);
    pulseIrq();
    busStart();
    chk("R10 start irq mode 5", irq, 1);
    pulseIrq();
    busStop();
    chk("R10 stop irq mode 5", irq, 1);
    cfg(4'h8, 10'h02A);
    pulseIrq();
    busStart();
    chk("R10 start irq mode 8", irq, 1);
    busStop();
    pulseIrq();

    // Transmit
    cfg(4'h1, 10'h02A);
    txData = 8'h96; txWe = 1'b1; w(1); txWe = 1'b0;
    busStart();
    sendByte(8'h55, ack);
    chk("R11 read address ack", ack, 1);
    pulseRd();
    pulseIrq();
    readByte(1'b1, b);
    chk("R11 first byte", b, 8'h96);
    chk("R7 irq on sent byte", irq, 1);
    readByte(1'b0, b);
    chk("R11 repeated byte", b, 8'h96);
    w(4);
    chk("R11 released after nack", sdaDrvLow, 0);
    busStop();
    pulseIrq();

    // Disabled block
    enable = 1'b0;
    w(2);
    chk("R12 no drive when off", sdaDrvLow, 0);
    busStart();
    sendByte(8'h54, ack);
    chk("R12 no ack when off", ack, 0);
    chk("R12 no load when off", bufFull, 0);
    busStop();
    enable = 1'b1;

    summary();
    $finish;
  end

endmodule